// File: doc/BRIEF.md
# Parallel i80 Panel Write Sequencer

This block performs one 8080-style parallel write to a panel controller for every word it accepts. A word arrives with a data/command flag through a valid/ready handshake. The block then puts the flag on the command line and the word on the data bus. It lowers chip select and then lowers the write strobe, releasing them in reverse order. The length of each of the four phases is set by timing fields that are captured when the word is accepted.

Each phase lasts its field value plus one clock. The first phase runs from the command line becoming valid to chip select falling. The second runs from chip select falling to the strobe falling. The third is the strobe-low width. The fourth runs from the strobe rising to chip select rising. When `tmg_custom` is low, the fixed defaults apply instead of the inputs: 0, 0, 1 and 0 in that phase order.

The controller moves through named states: IDLE to ADDR on acceptance, ADDR to CS_SETUP, CS_SETUP to STROBE, STROBE to HOLD, and HOLD back to IDLE. Each timed state leaves when its phase counter reaches zero.

Top module: `i80_write_seq`

## Requirements
- R1: `in_ready` is 1 only while `busy` is 0. A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `busy` is 1 from the acceptance edge until the edge where `lcd_cs_n` returns to 1.
- R2: `lcd_cs_n` falls cs_setup+1 clock cycles after the acceptance edge, which is also the edge at which `lcd_dc` and `lcd_data` take the new word.
- R3: `lcd_wr_n` falls wr_setup+1 clock cycles after `lcd_cs_n` falls.
- R4: `lcd_wr_n` stays 0 for exactly wr_active+1 clock cycles.
- R5: `lcd_cs_n` rises wr_hold+1 clock cycles after `lcd_wr_n` rises.
- R6: With `tmg_custom` = 0, the phases use cs_setup=0, wr_setup=0, wr_active=1 and wr_hold=0, whatever the `cfg_*` inputs hold.
- R7: The timing inputs and `tmg_custom` are sampled at acceptance. Changing them during a transfer leaves that transfer's phase lengths unchanged.
- R8: While idle, `lcd_cs_n` and `lcd_wr_n` are both 1. `lcd_wr_n` is 0 only while `lcd_cs_n` is 0.
- R9: `lcd_dc` and `lcd_data` hold the accepted flag and word for the whole transfer, including the strobe-low cycles, and keep them until the next acceptance.
- R10: `done` is a single-cycle pulse, high exactly in the first cycle in which `lcd_cs_n` is back at 1.
- R11: A synchronous active-high `rst` sets `lcd_cs_n` and `lcd_wr_n` to 1, `lcd_dc` and `lcd_data` to 0, `busy` and `done` to 0, and `in_ready` to 1.
- R12: Between two chip-select-low windows there is at least one cycle with `lcd_cs_n` = 1, even when words are offered back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block is idle and can accept |
| in_dc | input | 1 | Data/command flag for the word |
| in_data | input | DATA_W | Word to write |
| tmg_custom | input | 1 | 1: use cfg_* fields, 0: use fixed defaults |
| cfg_cs_setup | input | TMG_W | Command-valid to chip-select phase, minus one |
| cfg_wr_setup | input | TMG_W | Chip-select to strobe phase, minus one |
| cfg_wr_active | input | TMG_W | Strobe-low width, minus one |
| cfg_wr_hold | input | TMG_W | Strobe-release to chip-select-release phase, minus one |
| lcd_dc | output | 1 | Command/data line to panel |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_data | output | DATA_W | Parallel data bus |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse as chip select releases |

## Verification
The hardest situation to reach from the ports is a timing-field change that lands in the middle of a transfer. The phase lengths must still follow the values that were captured at acceptance. After every acceptance, the stimulus drives fresh random values onto all timing inputs and onto `tmg_custom`, then measures each phase length at the pins. Back-to-back offers, where the next word is presented in the `done` cycle, exercise the minimum chip-select gap. Directed runs with every field at 0 and at 255 cover the shortest and longest phases.

// File: rtl/i80_seq_pkg.sv
package i80_seq_pkg;
    localparam int TMG_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CS_SETUP,
        ST_STROBE,
        ST_HOLD
    } seq_state_t;

    typedef struct packed {
        logic [TMG_W-1:0] cs_setup;
        logic [TMG_W-1:0] wr_setup;
        logic [TMG_W-1:0] wr_active;
        logic [TMG_W-1:0] wr_hold;
    } tmg_t;
endpackage

// File: rtl/i80_phase_timer.sv
module i80_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/i80_word_latch.sv
module i80_word_latch
    import i80_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              dc_in,
    input  logic [DATA_W-1:0] data_in,
    input  tmg_t              tmg_in,
    output logic              dc_q,
    output logic [DATA_W-1:0] data_q,
    output tmg_t              tmg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dc_q   <= 1'b0;
            data_q <= '0;
            tmg_q  <= '0;
        end else if (capture) begin
            dc_q   <= dc_in;
            data_q <= data_in;
            tmg_q  <= tmg_in;
        end
    end
endmodule

// File: rtl/i80_write_seq.sv
module i80_write_seq
    import i80_seq_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int DEF_CS_SETUP  = 0,
    parameter int DEF_WR_SETUP  = 0,
    parameter int DEF_WR_ACTIVE = 1,
    parameter int DEF_WR_HOLD   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_dc,
    input  logic [DATA_W-1:0] in_data,
    input  logic              tmg_custom,
    input  logic [TMG_W-1:0]  cfg_cs_setup,
    input  logic [TMG_W-1:0]  cfg_wr_setup,
    input  logic [TMG_W-1:0]  cfg_wr_active,
    input  logic [TMG_W-1:0]  cfg_wr_hold,
    output logic              lcd_dc,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic [DATA_W-1:0] lcd_data,
    output logic              busy,
    output logic              done
);
    localparam tmg_t DEF_TMG = '{
        cs_setup:  TMG_W'(DEF_CS_SETUP),
        wr_setup:  TMG_W'(DEF_WR_SETUP),
        wr_active: TMG_W'(DEF_WR_ACTIVE),
        wr_hold:   TMG_W'(DEF_WR_HOLD)
    };

    seq_state_t       state_q, state_d;
    tmg_t             tmg_eff, tmg_cap;
    logic             accept;
    logic             phase_end;
    logic             tmr_load;
    logic [TMG_W-1:0] tmr_val;
    logic             done_q;

    assign tmg_eff = tmg_custom ? '{cs_setup: cfg_cs_setup, wr_setup: cfg_wr_setup,
                                    wr_active: cfg_wr_active, wr_hold: cfg_wr_hold}
                                : DEF_TMG;
    assign accept  = in_valid && (state_q == ST_IDLE);

    i80_word_latch #(.DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .dc_in   (in_dc),
        .data_in (in_data),
        .tmg_in  (tmg_eff),
        .dc_q    (lcd_dc),
        .data_q  (lcd_data),
        .tmg_q   (tmg_cap)
    );

    i80_phase_timer #(.W(TMG_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (phase_end)
    );

    // Next state and next phase length
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_ADDR;
                    tmr_load = 1'b1;
                    tmr_val  = tmg_eff.cs_setup;
                end
            end
            ST_ADDR: begin
                if (phase_end) begin
                    state_d  = ST_CS_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = tmg_cap.wr_setup;
                end
            end
            ST_CS_SETUP: begin
                if (phase_end) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = tmg_cap.wr_active;
                end
            end
            ST_STROBE: begin
                if (phase_end) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = tmg_cap.wr_hold;
                end
            end
            ST_HOLD: begin
                if (phase_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_HOLD) && phase_end;
        end
    end

    // Outputs decoded from state
    always_comb begin
        lcd_cs_n = 1'b1;
        lcd_wr_n = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_ADDR: begin
                lcd_cs_n = 1'b1;
            end
            ST_CS_SETUP, ST_HOLD: begin
                lcd_cs_n = 1'b0;
            end
            ST_STROBE: begin
                lcd_cs_n = 1'b0;
                lcd_wr_n = 1'b0;
            end
            default: begin
                lcd_cs_n = 1'b1;
            end
        endcase
    end

    assign in_ready = (state_q == ST_IDLE);
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
endmodule

// File: rtl/i80_write_seq_checker.sv
module i80_write_seq_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              lcd_dc,
    input logic              lcd_cs_n,
    input logic              lcd_wr_n,
    input logic [DATA_W-1:0] lcd_data,
    input logic              busy,
    input logic              done
);
    a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !busy);

    a_r8_idle_lines_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lcd_cs_n && lcd_wr_n));

    a_r8_strobe_inside_select: assert property (@(posedge clk) disable iff (rst)
        !lcd_wr_n |-> !lcd_cs_n);

    a_r9_bus_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy -> ($stable(lcd_data) && $stable(lcd_dc))));

    a_r10_done_on_release: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_cs_n) |-> done);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_gap_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_cs_n) |=> lcd_cs_n);
endmodule

bind i80_write_seq i80_write_seq_checker #(.DATA_W(DATA_W)) u_checker (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .lcd_dc   (lcd_dc),
    .lcd_cs_n (lcd_cs_n),
    .lcd_wr_n (lcd_wr_n),
    .lcd_data (lcd_data),
    .busy     (busy),
    .done     (done)
);

// File: tb/i80_write_seq_bench.sv
module i80_write_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int TW         = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              in_dc = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              tmg_custom = 1'b0;
    logic [TW-1:0]     cfg_cs_setup = '0, cfg_wr_setup = '0, cfg_wr_active = '0, cfg_wr_hold = '0;
    logic              lcd_dc, lcd_cs_n, lcd_wr_n, busy, done;
    logic [DATA_W-1:0] lcd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i80_write_seq #(.DATA_W(DATA_W)) u_i80_write_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_dc(in_dc), .in_data(in_data), .tmg_custom(tmg_custom),
        .cfg_cs_setup(cfg_cs_setup), .cfg_wr_setup(cfg_wr_setup),
        .cfg_wr_active(cfg_wr_active), .cfg_wr_hold(cfg_wr_hold),
        .lcd_dc(lcd_dc), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
        .lcd_data(lcd_data), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected phase length from the field value and the custom select
    function automatic int exp_len(input bit custom, input int field, input int dflt);
        return (custom ? field : dflt) + 1;
    endfunction

    function automatic logic [TW-1:0] pick_tmg();
        int r = $urandom % 10;
        if (r == 0) return 8'd255;
        return TW'($urandom % 5);
    endfunction

    task automatic scramble_cfg();
        tmg_custom    = 1'($urandom);
        cfg_cs_setup  = TW'($urandom);
        cfg_wr_setup  = TW'($urandom);
        cfg_wr_active = TW'($urandom);
        cfg_wr_hold   = TW'($urandom);
    endtask

    // Called at a negedge; offers a word and measures the transfer at the pins
    task automatic xfer(input bit dc, input logic [DATA_W-1:0] data, input bit custom,
                        input int c0, input int c1, input int c2, input int c3);
        int  na = 0, ns = 0, nw = 0, nh = 0;
        bit  seen_cs = 0, seen_wr = 0, ended = 0;
        chk("R1 ready when idle", in_ready, 1);
        in_valid      = 1'b1;
        in_dc         = dc;
        in_data       = data;
        tmg_custom    = custom;
        cfg_cs_setup  = TW'(c0);
        cfg_wr_setup  = TW'(c1);
        cfg_wr_active = TW'(c2);
        cfg_wr_hold   = TW'(c3);
        for (int k = 0; k < 2000 && !ended; k++) begin
            @(negedge clk);
            if (k == 0) begin
                in_valid = 1'b0;
                in_dc    = ~dc;
                in_data  = ~data;
                scramble_cfg();  // R7: must not disturb this transfer
                chk("R1 busy after accept", busy, 1);
                chk("R1 not ready while busy", in_ready, 0);
            end
            if (lcd_cs_n) begin
                if (!seen_cs) begin
                    na++;
                    chk("R10 no done during transfer", done, 0);
                    chk("R8 strobe high before select", lcd_wr_n, 1);
                end else begin
                    ended = 1;
                end
            end else begin
                seen_cs = 1;
                if (lcd_wr_n) begin
                    if (!seen_wr) ns++; else nh++;
                end else begin
                    seen_wr = 1;
                    nw++;
                    chk("R9 data during strobe", lcd_data, data);
                end
            end
            if (!ended) begin
                chk("R9 dc held", lcd_dc, dc);
                chk("R1 busy through transfer", busy, 1);
            end
        end
        chk("R10 done with release", done, 1);
        chk("R1 busy low at release", busy, 0);
        chk("R1 ready at release", in_ready, 1);
        chk("R9 data held after", lcd_data, data);
        chk("R2 cs_setup phase", na, exp_len(custom, c0, 0));
        chk("R3 wr_setup phase", ns, exp_len(custom, c1, 0));
        chk("R4 wr_active phase", nw, exp_len(custom, c2, 1));
        chk("R5 wr_hold phase", nh, exp_len(custom, c3, 0));
        if (!custom) chk("R6 default total", na + ns + nw + nh, 5);
    endtask

    initial begin
        void'($urandom(32'd20240511));
        repeat (3) @(negedge clk);
        chk("R11 cs_n in reset", lcd_cs_n, 1);
        chk("R11 wr_n in reset", lcd_wr_n, 1);
        chk("R11 data in reset", lcd_data, 0);
        chk("R11 dc in reset", lcd_dc, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 ready after reset", in_ready, 1);
        chk("R11 busy after reset", busy, 0);
        chk("R11 done after reset", done, 0);

        // Directed corners
        xfer(1'b0, 16'h002C, 1'b1, 0, 0, 0, 0);
        xfer(1'b1, 16'hA5A5, 1'b0, 7, 9, 3, 5);      // R6 defaults despite inputs
        xfer(1'b1, 16'hFFFF, 1'b1, 255, 255, 255, 255);
        @(negedge clk);
        chk("R10 done pulse ends", done, 0);
        chk("R12 idle gap select high", lcd_cs_n, 1);
        // In the following cycles of idle, the strobe stays high (R8)
        repeat (3) begin
            @(negedge clk);
            chk("R8 idle strobe high", lcd_wr_n, 1);
        end

        // Random mix, some back to back (offered in the done cycle)
        for (int t = 0; t < 60; t++) begin
            if ($urandom % 3 == 0) repeat ($urandom % 4) @(negedge clk);
            xfer(1'($urandom), DATA_W'($urandom), ($urandom % 4) != 0,
                 pick_tmg(), pick_tmg(), pick_tmg(), pick_tmg());
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule